// File: doc/BRIEF.md
# Mailbox Receive Queue

This block sits on the receiving side of an inter-core mailbox. A sending core presents an entry on a push port: a 64-bit message together with the 3-bit number of the core that sent it. Each accepted entry is stored in a circular queue of `DEPTH` slots. Software reads the oldest entry through a small register window, then writes a trigger register to discard it and bring the next entry forward.

The queue reports its raw read and write slot pointers and a separate full flag. When the two pointers are equal, software tells a full queue from an empty one by that flag. The occupancy is write minus read when the write pointer is ahead, and depth minus read plus write when it has wrapped behind. A maskable interrupt signals that the queue holds data. Software clears it with a status write, and it comes back one cycle later if entries remain. A write of zero to the queue-reset register empties the queue at once.

Two state machines carry the behaviour. The queue machine has three states. `FS_EMPTY` moves to `FS_PARTIAL` on an accepted push. `FS_PARTIAL` moves to `FS_FULL` when a push makes the write pointer meet the read pointer, and to `FS_EMPTY` when a pop makes the read pointer meet the write pointer. `FS_FULL` moves to `FS_PARTIAL` on a pop. A queue reset sends any state to `FS_EMPTY`. The interrupt machine has two states. `IRQ_IDLE` moves to `IRQ_PEND` when the queue holds data and mask bit 0 is clear. `IRQ_PEND` returns to `IRQ_IDLE` on a clear write.

Top module: `mbox_rx_fifo`

## Requirements
- R1: Reading address 0x00 returns the head entry's sender number in bits [2:0]. Address 0x04 returns message bits [31:0] and address 0x08 returns message bits [63:32]. All three read as zero while the queue is empty.
- R2: An accepted push stores its entry at the write pointer in the same clock edge. The write pointer then advances by one and wraps from DEPTH-1 to 0.
- R3: A write to 0x0C with data bit 0 set advances the read pointer by one, wrapping from DEPTH-1 to 0. Such a write with bit 0 clear, or any such write while the queue is empty, leaves both pointers unchanged.
- R4: Address 0x14 reads the read pointer in bits [31:24], the write pointer in bits [23:16] and the full flag in bit 0, with all other bits zero. Equal pointers with the full flag clear mean empty.
- R5: A push while the queue is full is dropped, and the pointers and stored entries are left unchanged.
- R6: Address 0x24 reads DEPTH-1.
- R7: Address 0x1C is a 5-bit mask register that resets to 5'h1F and reads back what was written. Bit 0 set holds the interrupt output low.
- R8: The pending state is entered on the first clock edge at which the queue is non-empty and mask bit 0 is clear. The irq output is high while pending and unmasked. Address 0x18 bit 0 reads the pending state.
- R9: Writing 0x18 with bit 0 set clears the pending state. If the queue is still non-empty and unmasked, pending returns on the next edge.
- R10: Writing the value 0 to 0x10 empties the queue and sets both pointers to 0. This takes priority over a push or pop in the same cycle. A nonzero write there has no effect.
- R11: After reset the queue is empty, both pointers are 0, irq is low and the mask is 5'h1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push strobe from the sending side |
| push_id | input | 3 | Sender core number |
| push_msg | input | 64 | Message payload |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Not-empty interrupt |

## Verification
The bench fills the queue past its depth. A design that let the extra push through would overwrite the head entry or move the write pointer past the read pointer, and the drained data order would show it. The pointers are driven around the wrap point, so an off-by-one wrap would show up as a wrong status word. The clear-while-not-empty case is timed cycle by cycle: a design that re-raised the interrupt in the same cycle, or never re-raised it, would differ from the expected one-cycle low pulse. A queue reset issued together with a push checks priority: a design that let the push win would report one entry instead of an empty queue.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] A_HEAD_ID  = 6'h00;
    localparam logic [REG_AW-1:0] A_HEAD_LO  = 6'h04;
    localparam logic [REG_AW-1:0] A_HEAD_HI  = 6'h08;
    localparam logic [REG_AW-1:0] A_POP      = 6'h0C;
    localparam logic [REG_AW-1:0] A_QRESET   = 6'h10;
    localparam logic [REG_AW-1:0] A_STATUS   = 6'h14;
    localparam logic [REG_AW-1:0] A_IRQ_STAT = 6'h18;
    localparam logic [REG_AW-1:0] A_IRQ_MASK = 6'h1C;
    localparam logic [REG_AW-1:0] A_DEPTH    = 6'h24;

    typedef enum logic [1:0] {
        FS_EMPTY,
        FS_PARTIAL,
        FS_FULL
    } fifo_state_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PEND
    } irq_state_e;
endpackage

// File: rtl/mbox_rx_store.sv
module mbox_rx_store
    import mbox_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 3,
    parameter int MSG_W = 64,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EW   = ID_W + MSG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [ID_W-1:0]  push_id,
    input  logic [MSG_W-1:0] push_msg,
    input  logic             pop_req,
    input  logic             flush_req,
    output logic [ID_W-1:0]  head_id,
    output logic [MSG_W-1:0] head_msg,
    output logic [PW-1:0]    wr_ptr,
    output logic [PW-1:0]    rd_ptr,
    output logic             full,
    output logic             empty
);
    fifo_state_e state_q, state_d;
    logic [EW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_nxt, rd_nxt;
    logic          push_ok, pop_ok;

    assign full    = (state_q == FS_FULL);
    assign empty   = (state_q == FS_EMPTY);
    assign push_ok = push_valid && !full && !flush_req;
    assign pop_ok  = pop_req && !empty && !flush_req;
    assign wr_nxt  = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    assign rd_nxt  = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

    // Next-state logic of the queue machine
    always_comb begin
        state_d = state_q;
        if (flush_req) begin
            state_d = FS_EMPTY;
        end else begin
            unique case (state_q)
                FS_EMPTY:   if (push_ok) state_d = (wr_nxt == rd_ptr) ? FS_FULL : FS_PARTIAL;
                FS_PARTIAL: begin
                    if (push_ok && !pop_ok && wr_nxt == rd_ptr) state_d = FS_FULL;
                    else if (pop_ok && !push_ok && rd_nxt == wr_ptr) state_d = FS_EMPTY;
                end
                FS_FULL:    if (pop_ok) state_d = (rd_nxt == wr_ptr) ? FS_EMPTY : FS_PARTIAL;
                default:    state_d = FS_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_EMPTY;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            if (flush_req) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= wr_nxt;
                if (pop_ok)  rd_ptr <= rd_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= {push_id, push_msg};
    end

    // Output logic: head entry, zero while empty
    always_comb begin
        if (empty) begin
            head_id  = '0;
            head_msg = '0;
        end else begin
            {head_id, head_msg} = slots[rd_ptr];
        end
    end
endmodule

// File: rtl/mbox_rx_irq.sv
module mbox_rx_irq
    import mbox_rx_pkg::*;
#(
    parameter int MASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nonempty,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              clr_req,
    output logic [MASK_W-1:0] mask,
    output logic              pend,
    output logic              irq
);
    irq_state_e state_q, state_d;

    // Next-state logic of the interrupt machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (nonempty && !mask[0]) state_d = IRQ_PEND;
            IRQ_PEND: if (clr_req) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            mask    <= '1;
        end else begin
            state_q <= state_d;
            if (mask_wr) mask <= mask_wdata;
        end
    end

    // Output logic
    always_comb begin
        pend = (state_q == IRQ_PEND);
        irq  = pend && !mask[0];
    end
endmodule

// File: rtl/mbox_rx_regs.sv
module mbox_rx_regs
    import mbox_rx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 3,
    parameter int MSG_W  = 64,
    parameter int MASK_W = 5,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [ID_W-1:0]   head_id,
    input  logic [MSG_W-1:0]  head_msg,
    input  logic [PW-1:0]     wr_ptr,
    input  logic [PW-1:0]     rd_ptr,
    input  logic              full,
    input  logic              pend,
    input  logic [MASK_W-1:0] mask,
    output logic              pop_req,
    output logic              flush_req,
    output logic              clr_req,
    output logic              mask_wr,
    output logic [31:0]       reg_rdata
);
    assign pop_req   = reg_wen && (reg_addr == A_POP) && reg_wdata[0];
    assign flush_req = reg_wen && (reg_addr == A_QRESET) && (reg_wdata == '0);
    assign clr_req   = reg_wen && (reg_addr == A_IRQ_STAT) && reg_wdata[0];
    assign mask_wr   = reg_wen && (reg_addr == A_IRQ_MASK);

    always_comb begin
        unique case (reg_addr)
            A_HEAD_ID:  reg_rdata = 32'(head_id);
            A_HEAD_LO:  reg_rdata = head_msg[31:0];
            A_HEAD_HI:  reg_rdata = head_msg[63:32];
            A_STATUS:   reg_rdata = {8'(rd_ptr), 8'(wr_ptr), 15'd0, full};
            A_IRQ_STAT: reg_rdata = 32'(pend);
            A_IRQ_MASK: reg_rdata = 32'(mask);
            A_DEPTH:    reg_rdata = 32'(DEPTH - 1);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
    import mbox_rx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 3,
    parameter int MSG_W  = 64,
    parameter int MASK_W = 5,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ID_W-1:0]   push_id,
    input  logic [MSG_W-1:0]  push_msg,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic [ID_W-1:0]   head_id;
    logic [MSG_W-1:0]  head_msg;
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic              full, empty, pend;
    logic              pop_req, flush_req, clr_req, mask_wr;
    logic [MASK_W-1:0] mask;

    mbox_rx_store #(.DEPTH(DEPTH), .ID_W(ID_W), .MSG_W(MSG_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_id(push_id), .push_msg(push_msg),
        .pop_req(pop_req), .flush_req(flush_req),
        .head_id(head_id), .head_msg(head_msg),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty)
    );

    mbox_rx_irq #(.MASK_W(MASK_W)) irq_i (
        .clk(clk), .rst_n(rst_n), .nonempty(!empty),
        .mask_wr(mask_wr), .mask_wdata(reg_wdata[MASK_W-1:0]),
        .clr_req(clr_req), .mask(mask), .pend(pend), .irq(irq)
    );

    mbox_rx_regs #(.DEPTH(DEPTH), .ID_W(ID_W), .MSG_W(MSG_W), .MASK_W(MASK_W)) regs_i (
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .head_id(head_id), .head_msg(head_msg),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .pend(pend), .mask(mask),
        .pop_req(pop_req), .flush_req(flush_req), .clr_req(clr_req),
        .mask_wr(mask_wr), .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/mbox_rx_fifo_chk.sv
module mbox_rx_fifo_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          pop_req,
    input logic          flush_req,
    input logic          clr_req,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic          full,
    input logic          empty,
    input logic          pend,
    input logic          mask0,
    input logic          irq
);
    // R5
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_valid && !flush_req && !pop_req) |=> ($stable(wr_ptr) && $stable(rd_ptr) && full));
    // R3
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !flush_req && !push_valid) |=> ($stable(rd_ptr) && $stable(wr_ptr) && empty));
    // R10
    queue_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (empty && wr_ptr == '0 && rd_ptr == '0));
    // R4
    full_ptr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full || empty) |-> (wr_ptr == rd_ptr));
    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !mask0);
    // R8
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(!empty && !mask0));
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr_req) |=> !pend);
endmodule

bind mbox_rx_fifo mbox_rx_fifo_chk #(.PW(PW)) chk_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
    .flush_req(flush_req), .clr_req(clr_req), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty), .pend(pend), .mask0(mask[0]), .irq(irq)
);

// File: tb/mbox_rx_fifo_tb.sv
module mbox_rx_fifo_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [2:0]  push_id = '0;
    logic [63:0] push_msg = '0;
    logic        reg_wen = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model of the queue
    logic [2:0]  m_id [DEPTH];
    logic [63:0] m_msg [DEPTH];
    int m_wr = 0, m_rd = 0, m_cnt = 0, seq = 0;

    always #5 clk = ~clk;

    mbox_rx_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_id(push_id),
        .push_msg(push_msg), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic push(input logic [2:0] id, input logic [63:0] msg);
        @(negedge clk);
        push_valid = 1'b1; push_id = id; push_msg = msg;
        @(negedge clk);
        push_valid = 1'b0;
        if (m_cnt < DEPTH) begin
            m_id[m_wr] = id; m_msg[m_wr] = msg;
            m_wr = (m_wr + 1) % DEPTH; m_cnt++;
        end
    endtask

    task automatic pop_model();
        wr(6'h0C, 32'h1);
        if (m_cnt > 0) begin
            m_rd = (m_rd + 1) % DEPTH; m_cnt--;
        end
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        rd(6'h14, v);
        check({req, " status"}, v, {8'(m_rd), 8'(m_wr), 15'd0, (m_cnt == DEPTH)});
        rd(6'h00, v);
        check({req, " head id"}, v, (m_cnt == 0) ? 32'd0 : 32'(m_id[m_rd]));
        rd(6'h04, v);
        check({req, " head lo"}, v, (m_cnt == 0) ? 32'd0 : m_msg[m_rd][31:0]);
        rd(6'h08, v);
        check({req, " head hi"}, v, (m_cnt == 0) ? 32'd0 : m_msg[m_rd][63:32]);
    endtask

    function automatic logic [63:0] next_msg();
        seq++;
        return {32'hC0DE_0000 + 32'(seq), 32'h1234_0000 ^ 32'(seq * 97)};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check_state("R11 R1");
        rd(6'h1C, v); check("R11 mask", v, 32'h1F);
        rd(6'h24, v); check("R6 depth", v, 32'(DEPTH - 1));
        check("R11 irq", 32'(irq), 32'd0);
    endtask

    task automatic t_push_pop();
        for (int i = 0; i < 3; i++) begin
            push(3'(i + 2), next_msg());
            check_state("R2 R1 push");
        end
        pop_model();
        check_state("R3 pop");
        wr(6'h0C, 32'h0);
        check_state("R3 trigger bit0 clear");
        pop_model(); pop_model();
        check_state("R4 empty after drain");
    endtask

    task automatic t_pop_empty();
        pop_model();
        check_state("R3 pop on empty");
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH; i++) push(3'(i), next_msg());
        check_state("R4 full");
        push(3'd7, 64'hDEAD_BEEF_DEAD_BEEF);
        check_state("R5 push dropped");
        for (int i = 0; i < DEPTH; i++) begin
            pop_model();
            check_state("R5 R2 drain order wrap");
        end
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(6'h1C, 32'h1E);
        rd(6'h1C, v); check("R7 mask readback", v, 32'h1E);
        check("R8 irq low when empty", 32'(irq), 32'd0);
        push(3'd5, next_msg());
        check("R8 irq latency", 32'(irq), 32'd0);
        @(negedge clk);
        check("R8 irq high", 32'(irq), 32'd1);
        rd(6'h18, v); check("R8 pending status", v, 32'd1);
        wr(6'h18, 32'h1);
        check("R9 cleared", 32'(irq), 32'd0);
        @(negedge clk);
        check("R9 reassert", 32'(irq), 32'd1);
        wr(6'h1C, 32'h1F);
        check("R7 masked irq", 32'(irq), 32'd0);
        wr(6'h1C, 32'h1E);
        check("R7 unmasked irq", 32'(irq), 32'd1);
        pop_model();
        wr(6'h18, 32'h1);
        @(negedge clk); @(negedge clk);
        check("R9 stays low when empty", 32'(irq), 32'd0);
    endtask

    task automatic t_queue_reset();
        push(3'd1, next_msg());
        push(3'd2, next_msg());
        wr(6'h10, 32'h5);
        check_state("R10 nonzero write ignored");
        wr(6'h10, 32'h0);
        m_wr = 0; m_rd = 0; m_cnt = 0;
        check_state("R10 reset");
        push(3'd3, next_msg());
        @(negedge clk);
        push_valid = 1'b1; push_id = 3'd4; push_msg = next_msg();
        reg_wen = 1'b1; reg_addr = 6'h10; reg_wdata = 32'h0;
        @(negedge clk);
        push_valid = 1'b0; reg_wen = 1'b0;
        m_wr = 0; m_rd = 0; m_cnt = 0;
        check_state("R10 priority over push");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_pop_empty();
        t_fill_overflow();
        t_irq();
        t_queue_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule